// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Direction

This block is one parallel I/O port on a small microcontroller's register bus. It holds an output data latch and a direction register. Each direction bit chooses, for one pin, whether the pad is driven from the latch or left as an input. Software reaches both registers through a single-cycle strobe interface with address, write flag, write data and combinational read data. Every pin has its own output value, output enable and input line.

Input levels pass through a two-stage synchroniser before they reach the read path. A read of the data register is assembled bit by bit: the latch value where the bit is an output, and the synchronised pin level where it is an input. Reset clears the direction register but leaves the latch untouched. After reset, software can restore the direction and find its last written data still in place.

A parameterised variant gives a fixed-input port with no direction register. Selected pins in this variant can be taken over by the output drivers of serial peripherals, and those drivers are held off while reset is active. Reset is asserted asynchronously and released through a two-flop synchroniser.

Top module: `gpio_port`

## Requirements
- R1: A direction bit of 1 drives the matching pin_oe bit high and presents the latch bit on pin_out. A direction bit of 0 leaves pin_oe low for that pin.
- R2: While rst_n is low, and for two clock edges after it rises, the direction register reads as zero and every pin_oe bit is low.
- R3: Reset does not alter the data latch. pin_out keeps the last written latch value through and after reset.
- R4: The direction register (address 1) can be read back. It returns the last value written to it.
- R5: A data register read (address 0) returns the latch value for every bit whose direction bit is 1.
- R6: For a bit whose direction bit is 0, a data read returns the pin level sampled two clocks earlier. A data write to that bit still updates the latch but does not set pin_oe.
- R7: A write (bus_sel=1, bus_wr=1) takes effect at the clock edge where it is presented. A read of the same register in the next cycle returns the new value.
- R8: Reads of unmapped addresses (2 and 3, and address 1 in the fixed-input variant) return zero. Writes to them change no register.
- R9: In the fixed-input variant there is no direction register. A pin in ALT_MASK whose alt_oe bit is high has pin_oe high and pin_out equal to alt_out.
- R10: In the fixed-input variant, alt_oe has no effect on pin_oe while reset is active or in the two-edge release window.
- R11: In the fixed-input variant, a data read returns the synchronised pin level, even on pins being driven by a peripheral.
- bus_rdata is zero whenever no read (bus_sel=1, bus_wr=0) is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 data, 1 direction |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, combinational |
| pin_in | input | WIDTH | Pin levels from the pads |
| pin_out | output | WIDTH | Values to drive on the pads |
| pin_oe | output | WIDTH | Per-pin output enable |
| alt_oe | input | WIDTH | Peripheral output enables (used on ALT_MASK pins) |
| alt_out | input | WIDTH | Peripheral output values (used on ALT_MASK pins) |

## Verification
A wrong direction bit shows on pin_oe in the cycle after the write that set it. The same error shows on the very next direction read. It also changes which source the data read takes for that bit. A latch corrupted by reset appears on pin_out directly after reset asserts, long before software would read it. A synchroniser of the wrong depth shifts every change of an input bit by a cycle in the read data, and the per-clock comparison catches that on the first toggle. A peripheral enable that leaks through reset appears on pin_oe of the fixed-input port within the same cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1
  } reg_addr_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_ok_o
);
  logic stage0_q;
  logic stage1_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_ok_o = stage1_q;
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_ok,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_ok) begin
      if (!rst_ok) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d_i[i];
        sync_q <= meta_q;
      end
    end

    assign q_o[i] = sync_q;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned AW      = gpio_pkg::REG_AW,
  parameter bit          HAS_DIR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_ok,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] pin_sync_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [WIDTH-1:0] lat_q,
  output logic [WIDTH-1:0] dir_q
);
  import gpio_pkg::*;

  logic             hit_data;
  logic             hit_dir;
  logic             wr_data;
  logic             wr_dir;
  logic             rd_en;
  logic [WIDTH-1:0] lat_d;

  assign hit_data = (addr_i == AW'(REG_DATA));
  assign hit_dir  = HAS_DIR && (addr_i == AW'(REG_DIR));
  assign wr_data  = rst_ok && sel_i && wr_i && hit_data;
  assign wr_dir   = rst_ok && sel_i && wr_i && hit_dir;
  assign rd_en    = sel_i && !wr_i;

  always_comb begin
    lat_d = lat_q;
    if (wr_data) lat_d = wdata_i;
  end

  always_ff @(posedge clk) begin
    if (wr_data) lat_q <= lat_d;
  end

  if (HAS_DIR) begin : g_dir
    logic [WIDTH-1:0] dir_d;

    always_comb begin
      dir_d = dir_q;
      if (wr_dir) dir_d = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_ok) begin
      if (!rst_ok) dir_q <= '0;
      else if (wr_dir) dir_q <= dir_d;
    end
  end else begin : g_nodir
    assign dir_q = '0;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      if (hit_data)     rdata_o = (lat_q & dir_q) | (pin_sync_i & ~dir_q);
      else if (hit_dir) rdata_o = dir_q;
    end
  end

  AST_DIR_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_dir |=> dir_q == $past(wdata_i)); // R7

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_ok)
    !wr_data |=> $stable(lat_q)); // R3

  AST_OUT_BITS_FROM_LATCH: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_en && hit_data) |-> ((rdata_o ^ lat_q) & dir_q) == '0); // R5

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_en && !hit_data && !hit_dir) |-> rdata_o == '0); // R8
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int unsigned      WIDTH    = 8,
  parameter logic [WIDTH-1:0] ALT_MASK = '0
) (
  input  logic             rst_ok,
  input  logic [WIDTH-1:0] lat_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] alt_oe_i,
  input  logic [WIDTH-1:0] alt_out_i,
  output logic [WIDTH-1:0] pin_out_o,
  output logic [WIDTH-1:0] pin_oe_o
);
  logic [WIDTH-1:0] alt_take;

  assign alt_take = alt_oe_i & ALT_MASK & {WIDTH{rst_ok}};

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pin_out_o[i] = alt_take[i] ? alt_out_i[i] : lat_q[i];
    assign pin_oe_o[i]  = alt_take[i] | dir_q[i];
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int unsigned      WIDTH    = 8,
  parameter bit               HAS_DIR  = 1'b1,
  parameter logic [WIDTH-1:0] ALT_MASK = '0,
  localparam int unsigned     AW       = gpio_pkg::REG_AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  input  logic [WIDTH-1:0] alt_oe,
  input  logic [WIDTH-1:0] alt_out
);
  logic             rst_ok;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] dir_q;

  gpio_rst_sync u_rst (
    .clk      (clk),
    .arst_n   (rst_n),
    .rst_ok_o (rst_ok)
  );

  gpio_sync2 #(.WIDTH(WIDTH)) u_sync (
    .clk    (clk),
    .rst_ok (rst_ok),
    .d_i    (pin_in),
    .q_o    (pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH), .AW(AW), .HAS_DIR(HAS_DIR)) u_regs (
    .clk        (clk),
    .rst_ok     (rst_ok),
    .sel_i      (bus_sel),
    .wr_i       (bus_wr),
    .addr_i     (bus_addr),
    .wdata_i    (bus_wdata),
    .pin_sync_i (pin_sync),
    .rdata_o    (bus_rdata),
    .lat_q      (lat_q),
    .dir_q      (dir_q)
  );

  gpio_pad_ctl #(.WIDTH(WIDTH), .ALT_MASK(ALT_MASK)) u_pad (
    .rst_ok    (rst_ok),
    .lat_q     (lat_q),
    .dir_q     (dir_q),
    .alt_oe_i  (alt_oe),
    .alt_out_i (alt_out),
    .pin_out_o (pin_out),
    .pin_oe_o  (pin_oe)
  );

  AST_ALT_OFF_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_ok |-> pin_oe == '0); // R10

  AST_INPUT_LAG: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_sel && !bus_wr && bus_addr == AW'(gpio_pkg::REG_DATA) && $past(rst_ok, 2))
      |-> ((bus_rdata ^ $past(pin_in, 2)) & ~dir_q) == '0); // R6
endmodule

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
  logic       clk;
  logic       rst_n;
  logic       sel, wr;
  logic [1:0] addr;
  logic [7:0] wdata, pin_in, alt_oe, alt_out;
  logic [7:0] rdata0, pout0, poe0;
  logic [6:0] rdata1, pout1, poe1;

  gpio_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata0), .pin_in(pin_in), .pin_out(pout0),
    .pin_oe(poe0), .alt_oe(alt_oe), .alt_out(alt_out)
  );

  gpio_port #(.WIDTH(7), .HAS_DIR(1'b0), .ALT_MASK(7'h3F)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata[6:0]), .bus_rdata(rdata1), .pin_in(pin_in[6:0]),
    .pin_out(pout1), .pin_oe(poe1), .alt_oe(alt_oe[6:0]), .alt_out(alt_out[6:0])
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    run = 0;
  bit    done = 0;
  string phase = "R2 reset";

  // behavioural model state
  logic [7:0] m_lat0 = 8'h00, m_dir = 8'h00, m_s1 = 8'h00, m_s2 = 8'h00;
  logic [6:0] m_lat1 = 7'h00;
  bit         m_known = 0;
  int         m_cnt = 0;

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit old_ok;
    old_ok = (m_cnt >= 2);
    if (!rst_n || !old_ok) begin
      m_s1 = 8'h00; m_s2 = 8'h00; m_dir = 8'h00;
    end else begin
      m_s2 = m_s1;
      m_s1 = pin_in;
      if (sel && wr && addr == 2'd0) begin
        m_lat0 = wdata; m_lat1 = wdata[6:0]; m_known = 1;
      end
      if (sel && wr && addr == 2'd1) m_dir = wdata;
    end
    if (!rst_n) m_cnt = 0;
    else if (m_cnt < 2) m_cnt++;
  end

  always @(negedge clk) begin
    if (run) begin
      bit         ok, rd;
      logic [7:0] dir, s2, exp0;
      logic [6:0] take, exp1, s2n;
      ok   = rst_n && (m_cnt >= 2);
      dir  = rst_n ? m_dir : 8'h00;
      s2   = rst_n ? m_s2  : 8'h00;
      s2n  = s2[6:0];
      rd   = sel && !wr;
      take = alt_oe[6:0] & 7'h3F & {7{ok}};
      chk("u0 pin_oe", poe0, dir);
      if (m_known) chk("u0 pin_out", pout0, m_lat0);
      chk("u1 pin_oe", {1'b0, poe1}, {1'b0, take});
      exp1 = (take & alt_out[6:0]) | (~take & m_lat1);
      if (m_known) chk("u1 pin_out", {1'b0, pout1}, {1'b0, exp1});
      else chk("u1 pin_out taken", {1'b0, pout1 & take}, {1'b0, alt_out[6:0] & take});
      exp0 = 8'h00;
      if (rd && addr == 2'd0) exp0 = (m_lat0 & dir) | (s2 & ~dir);
      if (rd && addr == 2'd1) exp0 = dir;
      if (m_known || dir == 8'h00) chk("u0 rdata", rdata0, exp0);
      chk("u1 rdata", {1'b0, rdata1}, (rd && addr == 2'd0) ? {1'b0, s2n} : 8'h00);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    sel = 1; wr = 1; addr = a; wdata = d;
    cyc(1);
    sel = 0; wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a);
    sel = 1; wr = 0; addr = a;
    cyc(1);
    sel = 0;
  endtask

  initial begin
    rst_n = 1; sel = 0; wr = 0; addr = 0; wdata = 0;
    pin_in = 8'h00; alt_oe = 8'h00; alt_out = 8'h00;
    #1 rst_n = 0;
    run = 1;
    // R2 and R10: reset state with peripheral enables requested
    phase = "R2 R10 reset";
    alt_oe = 8'hFF; alt_out = 8'h2A;
    cyc(4);
    rst_n = 1;
    cyc(1);
    phase = "R10 release window";
    cyc(3);
    alt_oe = 8'h00;
    // R7 and R4: direction write then read back
    phase = "R7 R4 dir readback";
    bus_write(2'd0, 8'h3C);
    bus_write(2'd1, 8'hA5);
    bus_read(2'd1);
    phase = "R1 drive";
    cyc(2);
    // R5: output bits read the latch while pins disagree
    phase = "R5 output read";
    pin_in = 8'hC3;
    cyc(3);
    bus_read(2'd0);
    bus_write(2'd1, 8'hFF);
    bus_read(2'd0);
    // R6: input bits, toggling pins and write to input bits
    phase = "R6 input read";
    bus_write(2'd1, 8'h0F);
    bus_write(2'd0, 8'h96);
    for (int i = 0; i < 12; i++) begin
      pin_in = 8'h11 * i[7:0] ^ 8'h5A;
      sel = 1; wr = 0; addr = 2'd0;
      cyc(1);
    end
    sel = 0;
    // R8: unmapped addresses
    phase = "R8 unmapped";
    bus_write(2'd2, 8'hFF);
    bus_write(2'd3, 8'h00);
    bus_read(2'd2);
    bus_read(2'd3);
    bus_read(2'd1);
    bus_read(2'd0);
    // R3: latch survives reset
    phase = "R3 latch retained";
    bus_write(2'd0, 8'h5A);
    bus_write(2'd1, 8'hF0);
    rst_n = 0;
    cyc(3);
    rst_n = 1;
    cyc(3);
    bus_read(2'd1);
    bus_write(2'd1, 8'hFF);
    bus_read(2'd0);
    // R9 and R11: fixed-input port with peripheral drivers
    phase = "R9 R11 peripheral drive";
    bus_write(2'd1, 8'h00);
    for (int i = 0; i < 10; i++) begin
      alt_oe  = 8'h7F ^ (8'h1D * i[7:0]);
      alt_out = 8'h33 + 8'h29 * i[7:0];
      pin_in  = 8'hE7 ^ (8'h0B * i[7:0]);
      sel = i[0]; wr = 0; addr = i[1] ? 2'd1 : 2'd0;
      cyc(1);
    end
    sel = 0; alt_oe = 8'hFF;
    cyc(2);
    phase = "R10 reset kills peripheral";
    rst_n = 0;
    cyc(2);
    rst_n = 1;
    cyc(4);
    alt_oe = 8'h00;
    cyc(2);
    run = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule